// File: doc/BRIEF.md
# ADC Serial Read Sequencer

This block drives a 16-bit converter whose result leaves over a serial line. On a start request it pulls the read/convert line low for a fixed number of system cycles, which begins a conversion. It then follows the converter's busy line and produces a data clock in short bursts from the system clock. The clock idles low between bursts. It shifts the serial data into a parallel word and marks the finished word with a one-cycle valid strobe.

Two read orderings are supported, and the choice is sampled when the start is accepted. In the overlapped ordering the burst begins as soon as busy is seen low, so the word that comes back is the one from the previous conversion. In the trailing ordering the burst waits for busy to return high and returns the word just converted. In that ordering the word can be preceded by a framing bit. To arm it, the first clock pulse is issued with chip select high. The bit is then checked, and an error flag records its absence. A second option moves the sampling point from the falling edge of a pulse to the rising edge of the next pulse, which costs one extra pulse.

Top module: `adc_rd_seq`

## Requirements
- R1: A `start` seen while the sequencer is idle drives `cs_n` low at once and holds `rd_conv` low for exactly RC_LOW cycles. A `start` seen at any other time is ignored, and no second conversion is issued.
- R2: In overlapped mode (`read_after`=0) the first rising edge of `dclk` appears one cycle after both of these hold: `rd_conv` is high again and `busy` is low. The word returned is the result of the previous conversion.
- R3: In trailing mode (`read_after`=1) no `dclk` pulse appears while `busy` is low. The first rising edge appears one cycle after `busy` returns high, and the word returned is the result of the current conversion.
- R4: `dclk` is low outside a burst. Inside a burst every high phase and every low phase lasts exactly HALF_DIV system cycles.
- R5: A burst has 16 pulses for falling-edge sampling and 17 for rising-edge sampling (`cap_rising`=1). With the framing bit enabled it has two more pulses (18 or 19).
- R6: Data arrives MSB first. With falling-edge sampling, bit k (k=0 is the MSB) is taken at the falling edge of data pulse k+1. With rising-edge sampling it is taken at the rising edge of data pulse k+2. Pulses are counted from 1 after any arming pulse.
- R7: During a burst `rd_conv` stays high. `cs_n` is low for every pulse except the arming pulse, which is issued with `cs_n` high and only when the framing bit is enabled.
- R8: With the framing bit enabled, `sync_err` rises if `sdata` is low at the framing bit's sample point, which is the first sample point of the burst. It stays low if `sdata` is high there, and a newly accepted start clears it.
- R9: After the final pulse's low phase, `result_vld` is high for exactly one cycle, with `result` holding the word and `cs_n` already back high. The sequencer is then idle.
- R10: `sync_lead` has no effect in overlapped mode: there is no arming pulse, the pulse count does not change and `sync_err` stays low.
- R11: `read_after`, `sync_lead` and `cap_rising` are sampled when a start is accepted. Changing them afterwards does not affect the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion and read |
| read_after | input | 1 | 0: read previous word during conversion; 1: read after busy rises |
| sync_lead | input | 1 | Enable arming pulse and framing bit (trailing mode only) |
| cap_rising | input | 1 | Sample on the rising edge of the following pulse |
| busy | input | 1 | Converter busy, low while converting (synchronous to clk) |
| sdata | input | 1 | Serial data from converter |
| rd_conv | output | 1 | Read/convert line, low pulse starts a conversion |
| cs_n | output | 1 | Chip select, active low |
| dclk | output | 1 | Gated data clock |
| result | output | DATA_W | Captured word |
| result_vld | output | 1 | One-cycle strobe, result is new |
| sync_err | output | 1 | Framing bit missing in last transfer |

## Verification
A converter model in the bench counts data clock edges, watches chip select during the first pulse, and answers with the old or the new word. The bench applies every combination of ordering, framing bit and sampling edge to several words with distinct bit patterns. A shifted capture point or an off-by-one pulse count then shows up as a wrong word or a wrong edge count. Words that differ between conversions show whether the previous or the current result was fetched. Runs with a missing framing bit, with the framing option set in overlapped mode, with configuration changes mid-transfer, and with a repeated start separate the error flag, the ignored option, configuration sampling and start filtering.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CONV    = 3'd1,
    ST_WAIT_LO = 3'd2,
    ST_WAIT_HI = 3'd3,
    ST_BURST   = 3'd4
  } rd_state_t;
endpackage

// File: rtl/adc_rd_clkgen.sv
// Burst generator: numbered pulses first_p..last_p, each phase HALF_DIV cycles.
// Event strobes are high in the cycle before the edge at which dclk changes.
module adc_rd_clkgen #(
  parameter int HALF_DIV = 5,
  parameter int PW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [PW-1:0] first_p,
  input  logic [PW-1:0] last_p,
  output logic          sclk_o,
  output logic          rise_ev_o,
  output logic          fall_ev_o,
  output logic [PW-1:0] evt_num_o,
  output logic          done_o
);
  localparam int HW = $clog2(HALF_DIV + 1);
  localparam logic [HW-1:0] HC_END = HW'(HALF_DIV - 1);

  logic          active_q, sclk_q;
  logic [HW-1:0] hc_q;
  logic [PW-1:0] pnum_q, last_q;
  logic          half_end, end_ev;

  assign half_end  = active_q && (hc_q == HC_END);
  assign rise_ev_o = go || (half_end && !sclk_q && (pnum_q != last_q));
  assign fall_ev_o = half_end && sclk_q;
  assign end_ev    = half_end && !sclk_q && (pnum_q == last_q);
  assign evt_num_o = go ? first_p : (sclk_q ? pnum_q : pnum_q + PW'(1));
  assign sclk_o    = sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      hc_q     <= '0;
      pnum_q   <= '0;
      last_q   <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= end_ev;
      if (go) begin
        active_q <= 1'b1;
        sclk_q   <= 1'b1;
        hc_q     <= '0;
        pnum_q   <= first_p;
        last_q   <= last_p;
      end else if (active_q) begin
        if (hc_q == HC_END) begin
          hc_q <= '0;
          if (sclk_q) begin
            sclk_q <= 1'b0;
          end else if (pnum_q == last_q) begin
            active_q <= 1'b0;
          end else begin
            sclk_q <= 1'b1;
            pnum_q <= pnum_q + PW'(1);
          end
        end else begin
          hc_q <= hc_q + HW'(1);
        end
      end
    end
  end

  // R9: a new burst is never requested on top of a running one
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
    go |-> !active_q);
  // R4: clock is low whenever no burst runs
  p_idle_low_r4: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> !sclk_q);
endmodule

// File: rtl/adc_rd_capture.sv
// Shift register for the serial word plus framing-bit check.
module adc_rd_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         samp_bit,
  input  logic         samp_sync,
  input  logic         sdata,
  output logic [W-1:0] word_o,
  output logic         sync_err_o
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word_o     <= '0;
      sync_err_o <= 1'b0;
    end else begin
      if (samp_bit)
        word_o <= {word_o[W-2:0], sdata};
      if (samp_sync && !sdata)
        sync_err_o <= 1'b1;
    end
  end

  // R6: a sample point is either a data bit or the framing bit, never both
  p_one_use_r6: assert property (@(posedge clk) disable iff (rst)
    !(samp_bit && samp_sync));
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq #(
  parameter int DATA_W   = 16,
  parameter int HALF_DIV = 5,
  parameter int RC_LOW   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              read_after,
  input  logic              sync_lead,
  input  logic              cap_rising,
  input  logic              busy,
  input  logic              sdata,
  output logic              rd_conv,
  output logic              cs_n,
  output logic              dclk,
  output logic [DATA_W-1:0] result,
  output logic              result_vld,
  output logic              sync_err
);
  import adc_rd_pkg::*;

  localparam int PW = $clog2(DATA_W + 4);
  localparam int CW = $clog2(RC_LOW + 1);

  rd_state_t     st;
  logic [CW-1:0] cnt_q;
  logic          after_q, sync_q, rise_q;
  logic          go, rise_ev, fall_ev, edge_ev, done, samp_bit, samp_sync, accept;
  logic [PW-1:0] off, first_p, last_p, evt_num;
  logic [DATA_W-1:0] word;

  assign accept    = (st == ST_IDLE) && start;
  assign off       = PW'(sync_q) + PW'(rise_q);
  assign first_p   = sync_q ? PW'(0) : PW'(1);
  assign last_p    = PW'(DATA_W) + off;
  assign go        = ((st == ST_WAIT_LO) && !busy && !after_q) ||
                     ((st == ST_WAIT_HI) && busy);
  assign edge_ev   = rise_q ? rise_ev : fall_ev;
  assign samp_bit  = edge_ev && (evt_num > off) && (evt_num <= PW'(DATA_W) + off);
  assign samp_sync = edge_ev && sync_q && (evt_num == off);

  adc_rd_clkgen #(.HALF_DIV(HALF_DIV), .PW(PW)) u_clkgen (
    .clk(clk), .rst(rst), .go(go), .first_p(first_p), .last_p(last_p),
    .sclk_o(dclk), .rise_ev_o(rise_ev), .fall_ev_o(fall_ev),
    .evt_num_o(evt_num), .done_o(done)
  );

  adc_rd_capture #(.W(DATA_W)) u_capture (
    .clk(clk), .rst(rst), .clr(accept), .samp_bit(samp_bit),
    .samp_sync(samp_sync), .sdata(sdata), .word_o(word), .sync_err_o(sync_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt_q      <= '0;
      after_q    <= 1'b0;
      sync_q     <= 1'b0;
      rise_q     <= 1'b0;
      rd_conv    <= 1'b1;
      cs_n       <= 1'b1;
      result     <= '0;
      result_vld <= 1'b0;
    end else begin
      result_vld <= 1'b0;
      if (rise_ev)
        cs_n <= (evt_num == PW'(0));
      case (st)
        ST_IDLE: if (start) begin
          st      <= ST_CONV;
          cnt_q   <= '0;
          after_q <= read_after;
          sync_q  <= sync_lead && read_after;
          rise_q  <= cap_rising;
          rd_conv <= 1'b0;
          cs_n    <= 1'b0;
        end
        ST_CONV: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(RC_LOW - 1)) begin
            rd_conv <= 1'b1;
            st      <= ST_WAIT_LO;
          end
        end
        ST_WAIT_LO: if (!busy) st <= after_q ? ST_WAIT_HI : ST_BURST;
        ST_WAIT_HI: if (busy) st <= ST_BURST;
        ST_BURST: if (done) begin
          result     <= word;
          result_vld <= 1'b1;
          cs_n       <= 1'b1;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: read/convert stays high while the data clock is high
  p_rc_high_r7: assert property (@(posedge clk) disable iff (rst)
    dclk |-> rd_conv);
  // R7: chip select high during a pulse only for the arming pulse
  p_cs_arm_r7: assert property (@(posedge clk) disable iff (rst)
    (dclk && cs_n) |-> sync_q);
  // R9: valid strobe lasts one cycle
  p_vld_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    result_vld |=> !result_vld);
  // R10: framing option never active in overlapped mode
  p_sync_mode_r10: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && !after_q) |-> !sync_q);
endmodule

// File: tb/adc_rd_seq_bench.sv
`timescale 1ns/1ps
module adc_rd_seq_bench;
  localparam int W = 16, HALF = 5, RCL = 2, CONV_CYC = 400;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, read_after = 0, sync_lead = 0, cap_rising = 0;
  logic busy = 1'b1, sdata = 1'b0;
  logic rd_conv, cs_n, dclk, result_vld, sync_err;
  logic [W-1:0] result;

  always #4 clk = ~clk;

  adc_rd_seq #(.DATA_W(W), .HALF_DIV(HALF), .RC_LOW(RCL)) u_adc_rd_seq (
    .clk(clk), .rst(rst), .start(start), .read_after(read_after),
    .sync_lead(sync_lead), .cap_rising(cap_rising), .busy(busy), .sdata(sdata),
    .rd_conv(rd_conv), .cs_n(cs_n), .dclk(dclk), .result(result),
    .result_vld(result_vld), .sync_err(sync_err)
  );

  int checks = 0, fails = 0;

  // ---------------- converter model ----------------
  logic [W-1:0] out_word = 16'hA5C3, next_word = '0;
  logic bad_sync = 0;
  int conv_cnt = 0, txn_id = 0;

  always @(posedge clk) begin
    if (!rst) begin
      if (conv_cnt == 0) begin
        if (!rd_conv && busy) begin conv_cnt <= 1; txn_id <= txn_id + 1; end
      end else begin
        conv_cnt <= conv_cnt + 1;
        if (conv_cnt == 1) busy <= 1'b0;
        if (conv_cnt == CONV_CYC) begin
          busy <= 1'b1; out_word <= next_word; conv_cnt <= 0;
        end
      end
    end
  end

  int k = 0, seen_id = 0, idx;
  logic armed = 0;
  always @(posedge dclk) begin
    if (seen_id != txn_id) begin seen_id = txn_id; k = 0; armed = 0; end
    if (cs_n) begin armed = 1; k = 0; end else k = k + 1;
    idx = armed ? k - 2 : k - 1;
    if (armed && k == 1) sdata <= !bad_sync;
    else if (idx >= 0 && idx < W) sdata <= out_word[W-1-idx];
    else sdata <= 1'b0;
  end

  // ---------------- monitor (negedge) ----------------
  int cyc = 0, rises_tot = 0, csr_tot = 0, rcl_tot = 0, vld_tot = 0, badw = 0;
  int hi_run = 0, lo_run = 0, fr_cyc = 0, rcr_cyc = 0, bf_cyc = 0, br_cyc = 0;
  logic sclk_p = 0, rc_p = 1, busy_p = 1, seen = 0, vld_cs = 0, vld_err = 0;
  logic [W-1:0] vld_data = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (dclk && !sclk_p) begin
        rises_tot++;
        if (cs_n) csr_tot++;
        if (!seen) begin seen = 1; fr_cyc = cyc; end
        else if (lo_run != HALF) badw++;
        hi_run = 1;
      end else if (dclk) hi_run++;
      if (!dclk && sclk_p) begin
        if (hi_run != HALF) badw++;
        lo_run = 1;
      end else if (!dclk) lo_run++;
      if (!rd_conv) rcl_tot++;
      if (rd_conv && !rc_p) rcr_cyc = cyc;
      if (!busy && busy_p) bf_cyc = cyc;
      if (busy && !busy_p) br_cyc = cyc;
      if (result_vld) begin
        vld_tot++; vld_data = result; vld_err = sync_err; vld_cs = cs_n; seen = 0;
      end
    end
    sclk_p = dclk; rc_p = rd_conv; busy_p = busy;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic m, input logic s, input logic r,
                         input logic [W-1:0] w, input logic bad, input logic pert);
    int r0, c0, l0, v0, b0, n;
    logic s_eff;
    logic [W-1:0] exp_w;
    @(negedge clk);
    read_after = m; sync_lead = s; cap_rising = r; next_word = w; bad_sync = bad;
    s_eff = s & m;
    exp_w = m ? w : out_word;
    r0 = rises_tot; c0 = csr_tot; l0 = rcl_tot; v0 = vld_tot; b0 = badw;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (pert) begin read_after = !m; sync_lead = !s; cap_rising = !r; end
    n = 0;
    while (vld_tot == v0 && n < 3000) begin
      @(negedge clk); n++;
      if (pert && n == 60) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    while (!(busy && conv_cnt == 0)) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(vld_tot - v0 == 1, "R9 valid count", vld_tot - v0, 1);
    chk(vld_cs == 1'b1, "R9 cs_n high at valid", vld_cs, 1);
    chk(vld_data == exp_w, m ? "R3/R6 word" : "R2/R6 word", vld_data, exp_w);
    chk(rises_tot - r0 == 16 + r + (s_eff ? 2 : 0), "R5 pulse count",
        rises_tot - r0, 16 + r + (s_eff ? 2 : 0));
    chk(csr_tot - c0 == (s_eff ? 1 : 0), s ? "R7/R10 arming pulses" : "R7 arming pulses",
        csr_tot - c0, s_eff ? 1 : 0);
    chk(badw == b0, "R4 phase width", badw - b0, 0);
    chk(rcl_tot - l0 == RCL, pert ? "R1 repeated start ignored" : "R1 convert pulse",
        rcl_tot - l0, RCL);
    chk(vld_err == (s_eff & bad), s && !m ? "R10 sync_err" : "R8 sync_err",
        vld_err, s_eff & bad);
    if (m) begin
      chk(fr_cyc - br_cyc == 1, pert ? "R11 trailing start" : "R3 burst after busy high",
          fr_cyc - br_cyc, 1);
    end else begin
      chk(fr_cyc - ((rcr_cyc > bf_cyc) ? rcr_cyc : bf_cyc) == 1, "R2 burst start",
          fr_cyc - ((rcr_cyc > bf_cyc) ? rcr_cyc : bf_cyc), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] w;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dclk == 0, "R4 reset dclk", dclk, 0);
    chk(cs_n == 1, "R9 reset cs_n", cs_n, 1);
    chk(rd_conv == 1, "R1 reset rd_conv", rd_conv, 1);
    chk(result_vld == 0, "R9 reset valid", result_vld, 0);
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int r = 0; r < 2; r++)
          for (int i = 0; i < 3; i++) begin
            w = W'(i * 16'h3A5D + m * 16'h1111 + s * 16'h0F0F + r * 16'h7000 + 16'h8001);
            run_txn(m[0], s[0], r[0], w, 1'b0, 1'b0);
          end
    run_txn(1'b1, 1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b0);  // R8 missing bit
    run_txn(1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0);  // R8 rising sampling
    run_txn(1'b1, 1'b1, 1'b0, 16'h1234, 1'b0, 1'b0);  // R8 cleared by start
    run_txn(1'b0, 1'b1, 1'b0, 16'hBEEF, 1'b1, 1'b0);  // R10 ignored
    run_txn(1'b1, 1'b1, 1'b0, 16'hC0DE, 1'b0, 1'b1);  // R11 / R1
    run_txn(1'b0, 1'b0, 1'b1, 16'h5A5A, 1'b0, 1'b1);  // R11 / R1
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule